// File: doc/BRIEF.md
# 4B5B Receive Aligner and Decoder

This block sits after the descrambler in a 100 Mb/s receive path. It accepts an unaligned serial stream, one bit on each cycle where the bit enable is high. It hunts for the start-of-stream delimiter, the J code-group followed by the K code-group, and only accepts that pair when a run of idle ones comes before it. Once the pair is found, the block fixes the code-group boundary. From then on it converts every 5-bit code-group into a 4-bit nibble on an MII-style receive interface: a data nibble, a data-valid level, an error level and a one-cycle symbol strobe.

The delimiter pair itself is delivered as two preamble nibbles. Decoded data follows one code-group behind the line, so the T/R end delimiter can be recognised before the T would reach the output. When T/R is seen, when the link is reported down, or when the signal detect drops, data-valid goes low. Alignment is then released and the hunt for a new J/K begins.

Top module: `rx4b5b_decoder`

## Requirements
- R1: While reset is asserted and after it is released, rxDv, rxEr and symStrobe are low and rxd is 0.
- R2: Alignment is taken from the 10-bit pattern 11000 then 10001, with the first received bit as the MSB of each code-group, at any bit offset. After that, each group of 5 accepted bits forms one code-group, and symStrobe pulses for exactly one cycle after the edge that accepts each group's last bit.
- R3: J/K starts a frame only when at least IDLE_BITS consecutive one bits come directly before the J. One fewer one bit leaves the block idle, with no strobe and rxDv low.
- R4: On the edge that accepts the last bit of K, rxDv rises together with a strobe carrying rxd=0101. The next strobe also carries 0101. After that, each strobe carries the code-group received one group earlier.
- R5: Data code-groups decode as follows, rxd[0] being the LSB: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R6: While rxDv is high, a code-group outside that table is output as rxd=0 with rxEr high for that strobe. A T (01101) that is not followed by R (00111) counts as such a code-group.
- R7: When an R code-group directly follows T, the strobe for R carries rxDv low, and the T is never output. Further code-groups produce no strobe until a new valid J/K arrives.
- R8: When linkOk or sigDet is low, rxDv and rxEr are low and symStrobe stays low from the next cycle on. Pending data is dropped and alignment is released.
- R9: Cycles with bitEn low shift nothing and produce no strobe. Decoding is the same for any spacing of enabled cycles.
- R10: A J/K pair received while linkOk or sigDet is low does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | Qualifies rxBit for one bit time |
| rxBit | input | 1 | Descrambled, unaligned serial bit |
| linkOk | input | 1 | Link monitor reports link up |
| sigDet | input | 1 | Signal energy present |
| rxd | output | 4 | Decoded nibble, bit 0 least significant |
| rxDv | output | 1 | Frame data valid |
| rxEr | output | 1 | Current nibble came from an invalid code-group |
| symStrobe | output | 1 | One-cycle pulse per delivered code-group |

## Verification
The bench builds the block with the default IDLE_BITS of 10. That value is small enough that directed streams can place exactly 9 and exactly 10 ones in front of a J and so probe both sides of the idle-run boundary. It sends frames after idle runs of different lengths, so the delimiter lands at several bit offsets. It also varies the number of disabled cycles between bits, which shows that alignment and decoding depend only on accepted bits.

// File: rtl/rx4b5b_pkg.sv
package rx4b5b_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  localparam logic [SYM_W-1:0] GRP_J = 5'b11000;
  localparam logic [SYM_W-1:0] GRP_K = 5'b10001;
  localparam logic [SYM_W-1:0] GRP_T = 5'b01101;
  localparam logic [SYM_W-1:0] GRP_R = 5'b00111;
  localparam logic [NIB_W-1:0] NIB_PRE = 4'b0101;

  // control -> datapath, at most one high per cycle
  typedef struct packed {
    logic lock;     // start delimiter accepted
    logic advance;  // shift one code-group through the output stage
    logic finish;   // end delimiter, close frame
    logic abort;    // link or signal lost
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic match;    // qualified J/K in window this cycle
    logic grpDone;  // code-group boundary reached this cycle
    logic endSeen;  // held group is T and the completing one is R
  } dpStatus_t;

  typedef struct packed {
    logic [NIB_W-1:0] nib;
    logic             bad;
    logic             isT;
  } grp_t;

  function automatic grp_t decodeGroup(input logic [SYM_W-1:0] g);
    grp_t r;
    r.bad = 1'b0;
    r.isT = (g == GRP_T);
    unique case (g)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      default: begin
        r.nib = '0;
        r.bad = 1'b1;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rx4b5b_datapath.sv
module rx4b5b_datapath
  import rx4b5b_pkg::*;
#(
  parameter int IDLE_BITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             rxBit,
  input  ctlStrobe_t       ctl,
  output dpStatus_t        st,
  output logic [NIB_W-1:0] rxd,
  output logic             rxDv,
  output logic             rxEr,
  output logic             symStrobe
);
  localparam int DELIM_W = 2 * SYM_W;
  localparam int WIN_W   = DELIM_W + IDLE_BITS;
  localparam int CNT_W   = $clog2(SYM_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYM_W - 1);

  logic [WIN_W-1:0] win;
  logic [WIN_W-1:0] nextWin;
  logic [CNT_W-1:0] bitCnt;
  logic             idleOk;
  logic             delimHit;
  grp_t             curGrp;
  grp_t             held;

  assign nextWin = {win[WIN_W-2:0], rxBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) win <= '0;
    else if (bitEn) win <= nextWin;
  end

  generate
    if (IDLE_BITS > 0) begin : g_idleChk
      assign idleOk = &nextWin[WIN_W-1 -: IDLE_BITS];
    end else begin : g_noIdleChk
      assign idleOk = 1'b1;
    end
  endgenerate

  assign delimHit = (nextWin[DELIM_W-1:0] == {GRP_J, GRP_K});
  assign curGrp   = decodeGroup(nextWin[SYM_W-1:0]);

  assign st.match   = bitEn && delimHit && idleOk;
  assign st.grpDone = bitEn && (bitCnt == CNT_LAST);
  assign st.endSeen = held.isT && (nextWin[SYM_W-1:0] == GRP_R);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (ctl.lock) bitCnt <= '0;
    else if (bitEn) bitCnt <= (bitCnt == CNT_LAST) ? '0 : bitCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held      <= '0;
      rxd       <= '0;
      rxDv      <= 1'b0;
      rxEr      <= 1'b0;
      symStrobe <= 1'b0;
    end else begin
      symStrobe <= 1'b0;
      if (ctl.abort) begin
        held <= '0;
        rxd  <= '0;
        rxDv <= 1'b0;
        rxEr <= 1'b0;
      end else if (ctl.lock) begin
        held      <= '{nib: NIB_PRE, bad: 1'b0, isT: 1'b0};
        rxd       <= NIB_PRE;
        rxDv      <= 1'b1;
        rxEr      <= 1'b0;
        symStrobe <= 1'b1;
      end else if (ctl.advance) begin
        held      <= curGrp;
        rxd       <= held.isT ? '0 : held.nib;
        rxEr      <= held.bad || held.isT;
        rxDv      <= 1'b1;
        symStrobe <= 1'b1;
      end else if (ctl.finish) begin
        held      <= '0;
        rxd       <= '0;
        rxDv      <= 1'b0;
        rxEr      <= 1'b0;
        symStrobe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx4b5b_ctrl.sv
module rx4b5b_ctrl
  import rx4b5b_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       linkOk,
  input  logic       sigDet,
  input  dpStatus_t  st,
  output ctlStrobe_t ctl
);
  typedef enum logic {ST_HUNT, ST_RUN} state_t;

  state_t state;
  state_t nextState;
  logic   linkGood;

  assign linkGood = linkOk && sigDet;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_HUNT: begin
        if (linkGood && st.match) begin
          ctl.lock  = 1'b1;
          nextState = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!linkGood) begin
          ctl.abort = 1'b1;
          nextState = ST_HUNT;
        end else if (st.grpDone && st.endSeen) begin
          ctl.finish = 1'b1;
          nextState  = ST_HUNT;
        end else if (st.grpDone) begin
          ctl.advance = 1'b1;
        end
      end
      default: nextState = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HUNT;
    else state <= nextState;
  end
endmodule

// File: rtl/rx4b5b_decoder.sv
module rx4b5b_decoder
  import rx4b5b_pkg::*;
#(
  parameter int IDLE_BITS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       rxBit,
  input  logic       linkOk,
  input  logic       sigDet,
  output logic [3:0] rxd,
  output logic       rxDv,
  output logic       rxEr,
  output logic       symStrobe
);
  ctlStrobe_t ctl;
  dpStatus_t  st;

  rx4b5b_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .linkOk (linkOk),
    .sigDet (sigDet),
    .st     (st),
    .ctl    (ctl)
  );

  rx4b5b_datapath #(.IDLE_BITS(IDLE_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .rxBit     (rxBit),
    .ctl       (ctl),
    .st        (st),
    .rxd       (rxd),
    .rxDv      (rxDv),
    .rxEr      (rxEr),
    .symStrobe (symStrobe)
  );
endmodule

// File: rtl/rx4b5b_chk.sv
module rx4b5b_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic       linkOk,
  input logic       sigDet,
  input logic [3:0] rxd,
  input logic       rxDv,
  input logic       rxEr,
  input logic       symStrobe
);
  AST_DV_RISE_PREAMBLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDv) |-> (symStrobe && rxd == 4'b0101)); // R4

  AST_LINK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!linkOk || !sigDet) |=> (!rxDv && !rxEr && !symStrobe)); // R8

  AST_ERR_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    rxEr |-> (rxDv && rxd == 4'h0)); // R6

  AST_STROBE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    symStrobe |-> $past(bitEn)); // R9

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    symStrobe |=> !symStrobe); // R2

  AST_DV_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxDv) |-> (symStrobe || $past(!linkOk || !sigDet))); // R7
endmodule

bind rx4b5b_decoder rx4b5b_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitEn     (bitEn),
  .linkOk    (linkOk),
  .sigDet    (sigDet),
  .rxd       (rxd),
  .rxDv      (rxDv),
  .rxEr      (rxEr),
  .symStrobe (symStrobe)
);

// File: tb/rx4b5b_decoder_tb.sv
module rx4b5b_decoder_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       rxBit = 1'b0;
  logic       linkOk = 1'b1;
  logic       sigDet = 1'b1;
  logic [3:0] rxd;
  logic       rxDv;
  logic       rxEr;
  logic       symStrobe;

  int checks = 0;
  int failures = 0;
  int stall = 0;
  bit done = 1'b0;

  localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101, R = 5'b00111;

  always #2.5 clk = ~clk;

  rx4b5b_decoder #(.IDLE_BITS(10)) u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit),
    .linkOk(linkOk), .sigDet(sigDet),
    .rxd(rxd), .rxDv(rxDv), .rxEr(rxEr), .symStrobe(symStrobe)
  );

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  task automatic expectOut(input string req, input logic eStb, input logic eDv,
                           input logic eEr, input logic [3:0] eD);
    checks++;
    if (symStrobe !== eStb || rxDv !== eDv || rxEr !== eEr || rxd !== eD) begin
      failures++;
      $display("FAIL %s: got stb=%b dv=%b er=%b rxd=%h, expected stb=%b dv=%b er=%b rxd=%h",
               req, symStrobe, rxDv, rxEr, rxd, eStb, eDv, eEr, eD);
    end
  endtask

  task automatic expectQuiet(input string req);
    checks++;
    if (symStrobe !== 1'b0 || rxDv !== 1'b0) begin
      failures++;
      $display("FAIL %s: got stb=%b dv=%b, expected stb=0 dv=0", req, symStrobe, rxDv);
    end
  endtask

  task automatic sendBit(input logic b);
    repeat (stall) @(negedge clk);
    rxBit = b;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
  endtask

  task automatic sendGroup(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) sendBit(g[i]);
  endtask

  task automatic sendRun(input int n, input logic b);
    for (int i = 0; i < n; i++) sendBit(b);
  endtask

  // full frame of n payload nibbles, all deliveries checked
  task automatic runFrame(input int idleBits, input int n, input logic [3:0] base, input string req);
    logic [3:0] p [16];
    for (int i = 0; i < 16; i++) p[i] = base + 4'(i);
    sendRun(idleBits, 1'b1);
    sendGroup(J);
    expectOut({req, " after J"}, 0, 0, 0, 4'h0);
    sendGroup(K);
    expectOut({req, " R4 first preamble"}, 1, 1, 0, 4'b0101);
    sendGroup(enc(p[0]));
    expectOut({req, " R4 second preamble"}, 1, 1, 0, 4'b0101);
    for (int i = 1; i < n; i++) begin
      sendGroup(enc(p[i]));
      expectOut({req, " R5 data"}, 1, 1, 0, p[i-1]);
    end
    sendGroup(T);
    expectOut({req, " R5 last data"}, 1, 1, 0, p[n-1]);
    sendGroup(R);
    expectOut({req, " R7 end strobe"}, 1, 0, 0, 4'h0);
    sendGroup(enc(4'h3));
    expectQuiet({req, " R7 no strobe after end"});
  endtask

  task automatic testReset();
    expectOut("R1 in reset", 0, 0, 0, 4'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectOut("R1 after reset", 0, 0, 0, 4'h0);
  endtask

  task automatic testIdleBoundary();
    sendRun(7, 1'b0);
    sendRun(9, 1'b1);
    sendGroup(J);
    sendGroup(K);
    expectQuiet("R3 nine ones then J/K");
    sendGroup(enc(4'h1));
    expectQuiet("R3 no frame started");
    sendRun(5, 1'b0);
    runFrame(10, 3, 4'h4, "R3 ten ones");
  endtask

  task automatic testBadGroup();
    sendRun(12, 1'b1);
    sendGroup(J); sendGroup(K);
    expectOut("R6 preamble", 1, 1, 0, 4'b0101);
    sendGroup(enc(4'h3));
    sendGroup(5'b00000);
    expectOut("R6 data before bad", 1, 1, 0, 4'h3);
    sendGroup(enc(4'h7));
    expectOut("R6 bad group", 1, 1, 1, 4'h0);
    sendGroup(T);
    expectOut("R6 good after bad", 1, 1, 0, 4'h7);
    sendGroup(R);
    expectOut("R7 close", 1, 0, 0, 4'h0);
  endtask

  task automatic testLoneT();
    sendRun(11, 1'b1);
    sendGroup(J); sendGroup(K);
    sendGroup(T);
    expectOut("R6 preamble before lone T", 1, 1, 0, 4'b0101);
    sendGroup(enc(4'h5));
    expectOut("R6 lone T is error", 1, 1, 1, 4'h0);
    sendGroup(T);
    expectOut("R6 data after lone T", 1, 1, 0, 4'h5);
    sendGroup(R);
    expectOut("R7 close after lone T", 1, 0, 0, 4'h0);
  endtask

  task automatic testDrop(input bit useSig);
    string tag;
    tag = useSig ? "R8 sigDet" : "R8 linkOk";
    sendRun(10, 1'b1);
    sendGroup(J); sendGroup(K); sendGroup(enc(4'h9)); sendGroup(enc(4'hA));
    expectOut({tag, " frame running"}, 1, 1, 0, 4'h9);
    if (useSig) sigDet = 1'b0; else linkOk = 1'b0;
    @(negedge clk);
    expectOut({tag, " dropped"}, 0, 0, 0, 4'h0);
    sigDet = 1'b1; linkOk = 1'b1;
    sendGroup(enc(4'h2));
    expectQuiet({tag, " no strobe after drop"});
    sendGroup(T); sendGroup(R);
    expectQuiet({tag, " still hunting"});
  endtask

  task automatic testLockWhileDown();
    linkOk = 1'b0;
    sendRun(10, 1'b1);
    sendGroup(J); sendGroup(K);
    expectQuiet("R10 J/K with link down");
    linkOk = 1'b1;
    sendGroup(enc(4'h6));
    expectQuiet("R10 no late frame");
    sigDet = 1'b0;
    sendRun(10, 1'b1);
    sendGroup(J); sendGroup(K);
    expectQuiet("R10 J/K with signal lost");
    sigDet = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    runFrame(13, 16, 4'h0, "R2 R5 all nibbles");
    runFrame(17, 4, 4'hC, "R2 other offset");
    testIdleBoundary();
    testBadGroup();
    testLoneT();
    testDrop(1'b0);
    testDrop(1'b1);
    runFrame(12, 2, 4'h8, "R8 recovery");
    testLockWhileDown();
    stall = 2;
    runFrame(14, 5, 4'hB, "R9 stalled bits");
    stall = 1;
    testBadGroup();
    stall = 0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule